// File: doc/BRIEF.md
# AES Key Schedule Expander

This block turns an AES cipher key of 128, 192 or 256 bits into the 32-bit round key words that a cipher round engine consumes. A key and its 2-bit size code are captured by a load pulse. An operation is then launched by a start pulse together with an operation code. The schedule can be delivered in two ways.

Streaming delivery produces words on the fly, in ascending index order, one per accepted transfer. It suits an encrypting engine that consumes round keys in the order they are generated. Store delivery first expands the whole schedule into an internal word memory, at one word per cycle. A later read-back operation replays that memory round by round from the last round to the first, which is the order a decrypting engine needs. Within each round the four words come out in ascending order.

Words leave through a valid/ready output. A word transfers on a clock edge where both `wd_valid` and `wd_ready` are high. The consumer may hold `wd_ready` low for any number of cycles. While it does, `wd_valid`, `wd_data` and `wd_last` stay unchanged. `wd_valid` is never withdrawn before the transfer. Control pins (load, start, done) are plain level/pulse signals.

Top module: `aes_key_sched`

## Requirements
- R1: After reset, `wd_valid` and `done` are low, and no stored schedule exists.
- R2: Size code 00, 01 and 10 give schedules of 44, 52 and 60 words (10, 12, 14 rounds). `wd_last` is high on the final word of an operation only.
- R3: Words 0 to Nk-1 (Nk = 4, 6, 8) equal the key. The key is left-aligned in `key_in`, so word 0 is bits 255:224, and a 128-bit key occupies bits 255:128.
- R4: Each word i ≥ Nk is word i-Nk XOR a transform of word i-1. When i mod Nk is 0, the transform is a byte rotate left, then the AES S-box on each byte, then an XOR of the round constant into the top byte. The round constant starts at 0x01 and doubles in GF(2^8). When Nk is 8 and i mod 8 is 4, the transform is the S-box only. Otherwise word i-1 is used unchanged.
- R5: Operation code 00 (stream) presents words in ascending index order, one per transfer. Data and last stay stable while stalled.
- R6: Operation code 01 (store) writes the whole schedule into memory with `wd_valid` low throughout. `done` rises exactly N cycles after the start edge, where N is the word count.
- R7: Operation code 10 (read back) delivers the stored schedule from round Nr down to round 0, ascending within each round. `wd_last` is set on word 3 of round 0.
- R8: A read-back start issued while no completed stored schedule exists is ignored: `wd_valid` stays low and `done` is unchanged.
- R9: The stored schedule and its size survive later key loads and streaming operations. Read-back uses the size in force when the schedule was stored.
- R10: A key load with size code 11 is ignored. The previous key and size stay in use.
- R11: Start and key load pulses arriving while an operation runs are ignored. A start with operation code 11 is ignored.
- R12: `done` clears on the edge that accepts a start. It goes high on the edge after the final word of the operation is transferred or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_in | input | 256 | Cipher key, left-aligned |
| key_size | input | 2 | Size code: 00=128, 01=192, 10=256 bits |
| key_load | input | 1 | Capture key and size code (idle only) |
| op_start | input | 1 | Launch operation (idle only) |
| op_sel | input | 2 | 00 stream, 01 store, 10 read back, 11 none |
| wd_valid | output | 1 | Word available |
| wd_ready | input | 1 | Consumer accepts word |
| wd_data | output | 32 | Round key word |
| wd_last | output | 1 | Final word of this operation |
| done | output | 1 | Last operation finished |

## Verification
An error in the generator's phase counter or round constant shows up at the first word that uses it. For 128-bit keys that is word 4, so a bad transform reaches the port within five transfers. A bad round constant step shows by word 8. A wrong read-back address counter shows on the very first read word, because that word must come from the last round. A misplaced stall hold shows on the first transfer after any cycle with ready low. Random keys and random back-pressure on all three sizes, plus a published 128-bit schedule, compare every word and every last flag against a bench model.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int WORD_W    = 32;
  localparam int KEY_W     = 256;
  localparam int MAX_NK    = 8;
  localparam int MAX_WORDS = 60;
  localparam int IDX_W     = $clog2(MAX_WORDS + 1);
  localparam int RND_W     = 4;

  typedef enum logic [1:0] {
    OP_STREAM = 2'b00,
    OP_STORE  = 2'b01,
    OP_READ   = 2'b10,
    OP_NONE   = 2'b11
  } ks_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STREAM,
    ST_EXPAND,
    ST_READ
  } ks_state_e;

  function automatic logic [7:0] gf_mul8(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (0 maps to 0), then the affine map
  function automatic logic [7:0] sbox_byte(input logic [7:0] x);
    logic [7:0] p;
    logic [7:0] r;
    logic [7:0] y;
    p = x;
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      p = gf_mul8(p, p);
      r = gf_mul8(r, p);
    end
    y = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]};
    return y ^ 8'h63;
  endfunction

  function automatic logic [3:0] nk_of(input logic [1:0] code);
    return 4'd4 + {1'b0, code, 1'b0};
  endfunction

  function automatic logic [RND_W-1:0] nr_of(input logic [1:0] code);
    return 4'd10 + {1'b0, code, 1'b0};
  endfunction
endpackage

// File: rtl/ks_sbox4.sv
module ks_sbox4
  import aes_ks_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NBYTES = W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign dout[8*g +: 8] = sbox_byte(din[8*g +: 8]);
  end
endmodule

// File: rtl/ks_word_gen.sv
module ks_word_gen
  import aes_ks_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int KW   = KEY_W,
  parameter int NKM  = MAX_NK,
  parameter int IW   = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          adv,
  input  logic [KW-1:0] key,
  input  logic [1:0]    code,
  output logic [W-1:0]  word,
  output logic [IW-1:0] idx
);
  localparam int JW = $clog2(NKM);

  logic [W-1:0]  win [NKM];
  logic [W-1:0]  key_words [NKM];
  logic [IW-1:0] cnt;
  logic [JW-1:0] ph;
  logic [7:0]    rcon;
  logic [3:0]    nk;
  logic [3:0]    nkm1;
  logic [W-1:0]  prev, far, sb_in, sb_out, xform;
  logic          in_key;

  for (genvar g = 0; g < NKM; g++) begin : g_kw
    assign key_words[g] = key[KW-1-W*g -: W];
  end

  assign nk     = nk_of(code);
  assign nkm1   = nk - 4'd1;
  assign prev   = win[0];
  assign far    = win[nkm1[JW-1:0]];
  assign in_key = (cnt < IW'(nk));
  assign sb_in  = (ph == '0) ? {prev[W-9:0], prev[W-1:W-8]} : prev;

  ks_sbox4 #(.W(W)) u_sub (.din(sb_in), .dout(sb_out));

  always_comb begin
    if (ph == '0)
      xform = sb_out ^ {rcon, {(W-8){1'b0}}};
    else if (nk == 4'd8 && ph == JW'(4))
      xform = sb_out;
    else
      xform = prev;
    word = in_key ? key_words[cnt[JW-1:0]] : (far ^ xform);
  end

  assign idx = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ph   <= '0;
      rcon <= 8'h01;
      for (int k = 0; k < NKM; k++) win[k] <= '0;
    end else if (init) begin
      cnt  <= '0;
      ph   <= '0;
      rcon <= 8'h01;
    end else if (adv) begin
      win[0] <= word;
      for (int k = 1; k < NKM; k++) win[k] <= win[k-1];
      cnt <= cnt + 1'b1;
      ph  <= (ph == nkm1[JW-1:0]) ? '0 : ph + 1'b1;
      if (!in_key && ph == '0)
        rcon <= {rcon[6:0], 1'b0} ^ (rcon[7] ? 8'h1b : 8'h00);
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= IW'(MAX_WORDS));
  p_first_rcon_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (rcon == 8'h01 && cnt == '0));
endmodule

// File: rtl/ks_store.sv
module ks_store
  import aes_ks_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = MAX_WORDS,
  parameter int IW = IDX_W,
  parameter int RW = RND_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rd_init,
  input  logic          rd_adv,
  input  logic [RW-1:0] rd_nr,
  output logic [W-1:0]  rdata,
  output logic          rd_last
);
  logic [W-1:0]    mem [NW];
  logic [RW-1:0]   rd_round;
  logic [1:0]      rd_sub;
  logic [RW+1:0]   raddr;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // four words per round: address is round*4 + position
  assign raddr   = {rd_round, rd_sub};
  assign rdata   = mem[raddr];
  assign rd_last = (rd_round == '0) && (rd_sub == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_round <= '0;
      rd_sub   <= '0;
    end else if (rd_init) begin
      rd_round <= rd_nr;
      rd_sub   <= '0;
    end else if (rd_adv) begin
      rd_sub <= rd_sub + 1'b1;
      if (rd_sub == 2'd3) rd_round <= rd_round - 1'b1;
    end
  end

  p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < IW'(NW)));
  p_rev_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv && !rd_init && rd_sub == 2'd3 && rd_round != '0) |=>
      (rd_sub == 2'd0 && rd_round == $past(rd_round) - 1'b1));
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
  import aes_ks_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int KW = KEY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [KW-1:0] key_in,
  input  logic [1:0]    key_size,
  input  logic          key_load,
  input  logic          op_start,
  input  logic [1:0]    op_sel,
  output logic          wd_valid,
  input  logic          wd_ready,
  output logic [W-1:0]  wd_data,
  output logic          wd_last,
  output logic          done
);
  ks_state_e         state;
  logic [KW-1:0]     key_q;
  logic [1:0]        code_q;
  logic [1:0]        st_code;
  logic              have_store;
  logic              accept;
  logic              gen_init, gen_adv, gen_last;
  logic [W-1:0]      gen_word, rd_word;
  logic [IDX_W-1:0]  gen_idx;
  logic [IDX_W-1:0]  total_m1;
  logic              rd_init, rd_adv, rd_last;
  logic              xfer;

  assign total_m1 = IDX_W'({nr_of(code_q), 2'b11});
  assign gen_last = (gen_idx == total_m1);

  assign accept = op_start && (state == ST_IDLE) && (op_sel != OP_NONE) &&
                  !(op_sel == OP_READ && !have_store);

  assign wd_valid = (state == ST_STREAM) || (state == ST_READ);
  assign wd_data  = (state == ST_READ) ? rd_word : gen_word;
  assign wd_last  = (state == ST_READ) ? rd_last : gen_last;
  assign xfer     = wd_valid && wd_ready;

  assign gen_init = accept && (op_sel != OP_READ);
  assign gen_adv  = (state == ST_EXPAND) || (state == ST_STREAM && wd_ready);
  assign rd_init  = accept && (op_sel == OP_READ);
  assign rd_adv   = (state == ST_READ) && wd_ready;

  ks_word_gen #(.W(W), .KW(KW)) u_gen (
    .clk(clk), .rst_n(rst_n), .init(gen_init), .adv(gen_adv),
    .key(key_q), .code(code_q), .word(gen_word), .idx(gen_idx)
  );

  ks_store #(.W(W)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(state == ST_EXPAND), .waddr(gen_idx), .wdata(gen_word),
    .rd_init(rd_init), .rd_adv(rd_adv), .rd_nr(nr_of(st_code)),
    .rdata(rd_word), .rd_last(rd_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      key_q      <= '0;
      code_q     <= 2'b00;
      st_code    <= 2'b00;
      have_store <= 1'b0;
      done       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            done <= 1'b0;
            case (op_sel)
              OP_STREAM: state <= ST_STREAM;
              OP_STORE: begin
                state      <= ST_EXPAND;
                have_store <= 1'b0;
              end
              default:   state <= ST_READ;
            endcase
          end else if (key_load && key_size != 2'b11) begin
            key_q  <= key_in;
            code_q <= key_size;
          end
        end
        ST_STREAM: begin
          if (xfer && gen_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_EXPAND: begin
          if (gen_last) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            have_store <= 1'b1;
            st_code    <= code_q;
          end
        end
        default: begin
          if (xfer && rd_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data) && $stable(wd_last)));
  p_done_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wd_last) |=> done);
  p_done_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done);
  p_read_needs_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ) |-> have_store);
  p_busy_key_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(key_q) && $stable(code_q)));
  p_size_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    code_q != 2'b11);
endmodule

// File: tb/sim_aes_key_sched.sv
module sim_aes_key_sched;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] key_in = '0;
  logic [1:0]   key_size = 2'b00;
  logic         key_load = 1'b0;
  logic         op_start = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic         wd_valid;
  logic         wd_ready = 1'b0;
  logic [31:0]  wd_data;
  logic         wd_last;
  logic         done;

  int nchecks = 0;
  int nerr = 0;
  int cyc = 0;

  logic [31:0] ref_w [60];
  logic [31:0] exp_w [60];
  logic [31:0] got_w [60];
  logic [31:0] st_w  [60];

  always #5 clk = ~clk;

  aes_key_sched u0 (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_size(key_size),
    .key_load(key_load), .op_start(op_start), .op_sel(op_sel),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .wd_last(wd_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] rsbox(input logic [7:0] x);
    logic [7:0] inv = 0;
    logic [7:0] s;
    logic [7:0] c = 8'h63;
    for (int y = 1; y < 256; y++)
      if (x != 0 && rmul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return s;
  endfunction

  function automatic logic [31:0] rsubw(input logic [31:0] w);
    return {rsbox(w[31:24]), rsbox(w[23:16]), rsbox(w[15:8]), rsbox(w[7:0])};
  endfunction

  task automatic build_ref(input logic [255:0] key, input int code);
    int nk = 4 + 2*code;
    int tot = 4*(11 + 2*code);
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 60; i++) ref_w[i] = '0;
    for (int i = 0; i < nk; i++) ref_w[i] = key[255-32*i -: 32];
    for (int i = nk; i < tot; i++) begin
      logic [31:0] t = ref_w[i-1];
      if (i % nk == 0) begin
        t = rsubw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = rmul(rc, 8'h02);
      end else if (nk == 8 && i % 8 == 4) begin
        t = rsubw(t);
      end
      ref_w[i] = ref_w[i-nk] ^ t;
    end
  endtask

  task automatic do_load(input logic [255:0] k, input logic [1:0] c);
    @(negedge clk);
    key_in = k; key_size = c; key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic do_start(input logic [1:0] op);
    @(negedge clk);
    op_start = 1'b1; op_sel = op;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  // collect a whole operation from the output port, with random stalls
  task automatic stream_run(input int code, input bit rev, input int pct, input string req);
    int n = 4*(11 + 2*code);
    int nr = 10 + 2*code;
    int k = 0;
    int guard = 0;
    bit fin = 0;
    bit stalled = 0;
    logic [31:0] held = '0;
    while (!fin && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (stalled && wd_valid) chk(wd_data == held, "R5", "stalled data changed", 64'(wd_data), 64'(held));
      stalled = 0;
      if (wd_valid) begin
        wd_ready = ($urandom_range(99) < pct);
        if (wd_ready) begin
          int ix = rev ? (4*(nr - k/4) + k%4) : k;
          if (ix > 59) ix = 0;
          chk(wd_data == exp_w[ix], req, $sformatf("word %0d", k), 64'(wd_data), 64'(exp_w[ix]));
          chk(wd_last == (k == n-1), "R2", $sformatf("last flag at %0d", k), 64'(wd_last), 64'(k == n-1));
          if (k < 60) got_w[k] = wd_data;
          k++;
          if (wd_last || k >= 60) fin = 1;
        end else begin
          stalled = 1;
          held = wd_data;
        end
      end else begin
        wd_ready = 1'b0;
      end
    end
    @(negedge clk);
    wd_ready = 1'b0;
    chk(k == n, "R2", "word count", 64'(k), 64'(n));
    chk(done == 1'b1, "R12", "done after last transfer", 64'(done), 64'd1);
  endtask

  task automatic expect_idle(input int ncyc, input logic done_exp, input string req);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      chk(wd_valid == 1'b0, req, "valid while idle", 64'(wd_valid), 64'd0);
      chk(done == done_exp, req, "done unchanged", 64'(done), 64'(done_exp));
    end
  endtask

  task automatic store_run(input int code);
    int n = 4*(11 + 2*code);
    int c = 0;
    bit quiet = 1;
    do_start(2'b01);
    chk(done == 1'b0, "R12", "done cleared by start", 64'(done), 64'd0);
    while (!done && c < 200) begin
      if (wd_valid) quiet = 0;
      @(negedge clk);
      c++;
    end
    chk(c == n, "R6", "store cycles", 64'(c), 64'(n));
    chk(quiet, "R6", "valid during store", 64'(!quiet), 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        nchecks++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] kA, kB, kC;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(wd_valid == 1'b0, "R1", "valid after reset", 64'(wd_valid), 64'd0);
    chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);

    // R8 (and R1: nothing stored yet): read-back ignored
    do_start(2'b10);
    expect_idle(5, 1'b0, "R8");

    // R3/R4 directed: published 128-bit example schedule
    kA = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
    do_load(kA, 2'b00);
    build_ref(kA, 0);
    exp_w = ref_w;
    do_start(2'b00);
    stream_run(0, 1'b0, 100, "R3");
    chk(got_w[0] == 32'h2b7e1516, "R3", "key word 0", 64'(got_w[0]), 64'h2b7e1516);
    chk(got_w[4] == 32'ha0fafe17, "R4", "word 4", 64'(got_w[4]), 64'ha0fafe17);
    chk(got_w[43] == 32'hb6630ca6, "R4", "word 43", 64'(got_w[43]), 64'hb6630ca6);

    // R4/R5 random keys, all sizes, random back-pressure
    for (int it = 0; it < 6; it++) begin
      logic [255:0] kr;
      int code = it % 3;
      for (int q = 0; q < 8; q++) kr[32*q +: 32] = $urandom();
      if (code == 0) kr[127:0] = '0;
      if (code == 1) kr[63:0] = '0;
      do_load(kr, 2'(code));
      build_ref(kr, code);
      exp_w = ref_w;
      do_start(2'b00);
      chk(done == 1'b0, "R12", "done cleared on stream start", 64'(done), 64'd0);
      stream_run(code, 1'b0, 30 + 10*it, "R4");
    end

    // R6/R7 store then reverse read, 256-bit then 192-bit
    for (int code = 2; code >= 1; code--) begin
      for (int q = 0; q < 8; q++) kB[32*q +: 32] = $urandom();
      if (code == 1) kB[63:0] = '0;
      do_load(kB, 2'(code));
      build_ref(kB, code);
      store_run(code);
      exp_w = ref_w;
      do_start(2'b10);
      stream_run(code, 1'b1, 60, "R7");
    end
    st_w = ref_w;

    // R9: stored 192-bit schedule survives a new key and a stream
    for (int q = 0; q < 8; q++) kC[32*q +: 32] = $urandom();
    kC[127:0] = '0;
    do_load(kC, 2'b00);
    build_ref(kC, 0);
    exp_w = ref_w;
    do_start(2'b00);
    stream_run(0, 1'b0, 80, "R9");
    exp_w = st_w;
    do_start(2'b10);
    stream_run(1, 1'b1, 70, "R9");

    // R10: size code 11 load ignored, kC still in use
    do_load(~kC, 2'b11);
    build_ref(kC, 0);
    exp_w = ref_w;
    do_start(2'b00);
    stream_run(0, 1'b0, 90, "R10");

    // R11: load and start while busy ignored
    do_start(2'b00);
    @(negedge clk);
    key_in = ~kC; key_size = 2'b10; key_load = 1'b1; op_start = 1'b1; op_sel = 2'b01;
    @(negedge clk);
    key_load = 1'b0; op_start = 1'b0;
    stream_run(0, 1'b0, 50, "R11");

    // R11: operation code 11 ignored, done stays high
    do_start(2'b11);
    expect_idle(3, 1'b1, "R11");

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule